// File: doc/BRIEF.md
# SPI Byte Memory Slave

This block is an SPI mode-0 slave that puts a byte-wide memory array behind a serial link. A transaction starts when chip select falls. The host shifts in an 8-bit instruction, then a 16-bit address, most significant bit first. After that, data streams out of the array (read) or into it (write) for as long as chip select stays low. The address steps forward after every byte and wraps from the top of the array back to zero. Writes are gated by a write-enable latch. A host sets the latch with a dedicated instruction, and the latch drops again once a write transaction ends.

The SPI pins are sampled in a local clock domain. Each of them passes through a two-stage synchronizer, and edge detection is done on the synchronized serial clock. Two signals come from surrounding logic. The first is a protection verdict: the block presents its current write address on `prot_addr` and reads back `prot_hit` combinationally. The second is a busy flag. While it is high, read and write instructions are refused. The array holds 2^ADDR_W bytes, so ADDR_W = 15 gives 32K x 8. Address bits at and above ADDR_W are don't-care.

Top module: `spi_nvmem_slave`

## Requirements
- R1: A transaction starts at chip select fall. SI is sampled on SCK rising edges: an 8-bit instruction first, then 16 address bits, MSB first. Raising chip select at any point aborts the transaction, and the next fall expects a new instruction.
- R2: The array address is taken from the low ADDR_W bits of the 16-bit address field. Higher bits are ignored (A15 for a 32K array).
- R3: READ (0x03) drives the byte at the address on SO, MSB first. Each bit is updated after an SCK falling edge, and the first bit follows the fall after the last address bit. Bytes continue with the address incremented for as long as chip select stays low.
- R4: During a READ, SI bits after the address have no effect on the read data or on the array.
- R5: In both reads and writes, the address wraps from 2^ADDR_W-1 to 0 and the burst continues.
- R6: WRITE (0x02) is accepted only while the write-enable latch is set. WREN (0x06) sets the latch. When a WRITE arrives with the latch clear, its data is not stored.
- R7: The write-enable latch clears when chip select rises to end an accepted WRITE.
- R8: A write byte goes into the array only after all 8 data bits have been received. A partial byte at chip select rise is dropped.
- R9: A write byte whose address has `prot_hit` high is discarded, but the address still advances. Writing resumes at the next unprotected address, including after a wrap.
- R10: While `mem_busy` is high at instruction decode, READ and WRITE are ignored: SO is never enabled and the array is not modified.
- R11: An unrecognized instruction makes the block ignore SI until chip select rises. Later bytes that look like instructions are not decoded.
- R12: `spi_miso_en` is low after reset, whenever chip select is high, and whenever no read data is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that samples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock (mode 0) |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial read data |
| spi_miso_en | output | 1 | Output enable for the SO pad (low means high-impedance) |
| mem_busy | input | 1 | Store/recall in progress; blocks READ and WRITE |
| prot_addr | output | ADDR_W | Current write address presented for the protection check |
| prot_hit | input | 1 | High when `prot_addr` lies in a protected region |

## Verification
The bench goes after the following corner cases, and states what a faulty design would show for each.

- **Burst wrap.** Bursts cross the top of the array. A design that saturated or failed to wrap would return or store data at the wrong addresses.
- **Protected window.** A protected window sits in the middle of a write burst, and a second window sits just before a wrap. A design that stalled the address on a protected byte would shift every later byte down one slot. A design that stopped writing after a protected byte would leave the locations after the wrap unwritten.
- **Write-enable latch.** A write is attempted right after a completed write, without a fresh WREN. A design whose latch did not self-clear would corrupt the array.
- **Discarded input.** The bench sends a partial trailing byte, an all-ones pattern on SI during a read, a high address byte, an unknown instruction followed by a valid-looking write, and a read and a write while busy. A design that committed early, decoded SI mid-read, honoured high address bits, or decoded later bytes would show its fault in the read-back or in the SO enable.

// File: rtl/spi_nvmem_slave.sv
module spi_nvmem_slave #(
  parameter int          ADDR_W   = 10,
  parameter logic [7:0]  OP_READ  = 8'h03,
  parameter logic [7:0]  OP_WRITE = 8'h02,
  parameter logic [7:0]  OP_WREN  = 8'h06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_en,
  input  logic              mem_busy,
  output logic [ADDR_W-1:0] prot_addr,
  input  logic              prot_hit
);
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [2:0] {S_OPC, S_ADR, S_RD, S_WR, S_SKIP} state_t;

  logic [2:0] sck_s;
  logic [1:0] cs_s, mosi_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s  <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sck_s  <= {sck_s[1:0], spi_sck};
      cs_s   <= {cs_s[0], spi_cs_n};
      mosi_s <= {mosi_s[0], spi_mosi};
    end

  wire sck_rise = sck_s[1] & ~sck_s[2];
  wire sck_fall = ~sck_s[1] & sck_s[2];
  wire cs_hi    = cs_s[1];
  wire din      = mosi_s[1];

  state_t              state;
  logic [3:0]          cnt;
  logic [ADDR_W-2:0]   sr;
  logic [ADDR_W-1:0]   addr;
  logic [2:0]          bit_idx;
  logic                is_wr, wen, miso_q, miso_en_q;
  logic [7:0]          mem [DEPTH];

  wire [ADDR_W-1:0] word_in = {sr, din};
  wire [7:0]        byte_in = {sr[6:0], din};
  wire              mem_we  = sck_rise & ~cs_hi & (state == S_WR) & (cnt == 4'd7) & ~prot_hit;

  assign prot_addr   = addr;
  assign spi_miso    = miso_q;
  assign spi_miso_en = miso_en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= S_OPC;
      cnt       <= '0;
      sr        <= '0;
      addr      <= '0;
      bit_idx   <= '0;
      is_wr     <= 1'b0;
      wen       <= 1'b0;
      miso_q    <= 1'b0;
      miso_en_q <= 1'b0;
    end else if (cs_hi) begin
      state     <= S_OPC;
      cnt       <= '0;
      bit_idx   <= '0;
      miso_en_q <= 1'b0;
      if (state == S_WR || (state == S_ADR && is_wr)) wen <= 1'b0;
    end else begin
      if (sck_rise) begin
        sr  <= word_in[ADDR_W-2:0];
        cnt <= cnt + 4'd1;
        case (state)
          S_OPC: if (cnt == 4'd7) begin
            cnt <= '0;
            if (byte_in == OP_WREN) begin
              wen   <= 1'b1;
              state <= S_SKIP;
            end else if (byte_in == OP_READ && !mem_busy) begin
              is_wr <= 1'b0;
              state <= S_ADR;
            end else if (byte_in == OP_WRITE && !mem_busy && wen) begin
              is_wr <= 1'b1;
              state <= S_ADR;
            end else
              state <= S_SKIP;
          end
          S_ADR: if (cnt == 4'd15) begin
            cnt       <= '0;
            addr      <= word_in;
            state     <= is_wr ? S_WR : S_RD;
            miso_en_q <= ~is_wr;
          end
          S_WR: if (cnt == 4'd7) begin
            cnt  <= '0;
            addr <= addr + ADDR_W'(1);
          end
          default: ;
        endcase
      end
      if (sck_fall && state == S_RD) begin
        miso_q  <= mem[addr][~bit_idx];
        bit_idx <= bit_idx + 3'd1;
        if (bit_idx == 3'd7) addr <= addr + ADDR_W'(1);
      end
    end

  always_ff @(posedge clk)
    if (mem_we) mem[addr] <= byte_in;

  AST_SO_QUIET_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> !spi_miso_en); // R12
  AST_WRITE_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wen); // R6
  AST_WEN_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi && state == S_WR) |=> !wen); // R7
  AST_PROT_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && !cs_hi && state == S_WR && cnt == 4'd7 && prot_hit)
      |=> (addr == $past(addr) + ADDR_W'(1))); // R9
  AST_BUSY_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADR && $past(state) == S_OPC) |-> !$past(mem_busy)); // R10
  AST_READ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall && !cs_hi && state == S_RD && bit_idx == 3'd7 && addr == '1)
      |=> (addr == '0)); // R5
endmodule

// File: tb/spi_nvmem_slave_bench.sv
module spi_nvmem_slave_bench;
  localparam int AW   = 10;
  localparam int HALF = 6;

  logic clk = 0, rst_n = 0;
  logic sck = 0, cs_n = 1, mosi = 0, busy = 0;
  logic miso, miso_en;
  logic [AW-1:0] prot_addr;
  logic prot_on = 0;
  int   prot_lo = 0, prot_hi = 0;
  wire  prot_hit = prot_on && int'(prot_addr) >= prot_lo && int'(prot_addr) <= prot_hi;

  always #4 clk = ~clk;

  spi_nvmem_slave #(.ADDR_W(AW)) u_spi_nvmem_slave (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_en(miso_en), .mem_busy(busy),
    .prot_addr(prot_addr), .prot_hit(prot_hit));

  logic [7:0] model [1 << AW];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  int nvec = 0, nbad = 0;
  bit mon_on = 0, done = 0;
  logic [7:0] mon_sr;
  int mon_n;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit is_prot(int a);
    return prot_on && a >= prot_lo && a <= prot_hi;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(logic b);
    mosi = b; tick(HALF); sck = 1; tick(HALF); sck = 0;
  endtask

  task automatic sbyte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) xbit(b[i]);
  endtask

  task automatic csl; cs_n = 0; tick(4); endtask
  task automatic csh; tick(4); cs_n = 1; tick(8); endtask

  task automatic wren; csl(); sbyte(8'h06); csh(); endtask

  task automatic wr_burst(logic [15:0] a, int n, logic [7:0] seed, bit accepted);
    csl(); sbyte(8'h02); sbyte(a[15:8]); sbyte(a[7:0]);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = seed + 8'(i * 29);
      int ad = int'(AW'(a + 16'(i)));
      if (accepted && !is_prot(ad)) model[ad] = d;
      sbyte(d);
    end
    csh();
  endtask

  task automatic rd_burst(logic [15:0] a, int n, string tag, logic [7:0] junk);
    csl(); sbyte(8'h03); sbyte(a[15:8]); sbyte(a[7:0]);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[int'(AW'(a + 16'(i)))]);
      tag_q.push_back(tag);
    end
    mon_n = 0; mon_on = 1;
    for (int i = 0; i < n; i++) sbyte(junk);
    mon_on = 0;
    csh();
  endtask

  always @(posedge sck) if (mon_on) begin
    mon_sr = {mon_sr[6:0], miso};
    mon_n++;
    if (mon_n == 8) begin
      mon_n = 0;
      chk("R12 SO enabled during read data", 16'(miso_en), 16'd1);
      if (exp_q.size() == 0) chk("R3 unexpected read byte", 16'(mon_sr), 16'hFFFF);
      else begin
        string t = tag_q.pop_front();
        chk(t, 16'(mon_sr), 16'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    tick(5); rst_n = 1; tick(5);
    chk("R12 SO enable after reset", 16'(miso_en), 16'd0);

    wren(); wr_burst(16'h00F0, 16, 8'h11, 1);
    wren(); wr_burst(16'h0100, 8, 8'h42, 1);
    wren(); wr_burst(16'h03F8, 8, 8'h73, 1);
    wren(); wr_burst(16'h0000, 8, 8'h9C, 1);
    chk("R12 SO enable idle after writes", 16'(miso_en), 16'd0);

    rd_burst(16'h00F8, 16, "R3 burst read across 0x100", 8'h00);

    wr_burst(16'h00F0, 4, 8'hE0, 0);
    rd_burst(16'h00F0, 4, "R7 write after completed write without WREN", 8'h00);

    rd_burst(16'h0100, 4, "R4 read with SI held high", 8'hFF);
    rd_burst(16'h0100, 4, "R4 array unchanged by SI during read", 8'h00);

    wren(); wr_burst(16'hFC05, 2, 8'h5A, 1);
    rd_burst(16'h0005, 2, "R2 high address bits ignored", 8'h00);

    wren(); wr_burst(16'h03FE, 4, 8'hB1, 1);
    rd_burst(16'h03FD, 6, "R5 wrap on write and read", 8'h00);

    prot_on = 1; prot_lo = 'h101; prot_hi = 'h102;
    wren(); wr_burst(16'h0100, 4, 8'h27, 1);
    prot_on = 0;
    rd_burst(16'h0100, 4, "R9 protected bytes skipped mid-burst", 8'h00);
    prot_on = 1; prot_lo = 'h3FF; prot_hi = 'h3FF;
    wren(); wr_burst(16'h03FE, 3, 8'hD4, 1);
    prot_on = 0;
    rd_burst(16'h03FE, 3, "R9 writing resumes after wrap", 8'h00);

    wren();
    csl(); sbyte(8'h02); sbyte(8'h00); sbyte(8'h02);
    sbyte(8'h3C); model[2] = 8'h3C;
    for (int i = 0; i < 5; i++) xbit(1'b1);
    csh();
    rd_burst(16'h0002, 2, "R8 partial byte dropped", 8'h00);

    busy = 1;
    csl(); sbyte(8'h03); sbyte(8'h00); sbyte(8'hF0);
    for (int i = 0; i < 8; i++) begin
      xbit(1'b0);
      chk("R10 SO stays off for READ while busy", 16'(miso_en), 16'd0);
    end
    csh();
    wren(); wr_burst(16'h00F0, 2, 8'h66, 0);
    busy = 0;
    rd_burst(16'h00F0, 2, "R10 WRITE while busy ignored", 8'h00);

    wren();
    csl(); sbyte(8'hA5); sbyte(8'h02); sbyte(8'h00); sbyte(8'hF0);
    sbyte(8'h77); sbyte(8'h03);
    for (int i = 0; i < 8; i++) xbit(1'b0);
    chk("R11 SO off after unknown instruction", 16'(miso_en), 16'd0);
    csh();
    rd_burst(16'h00F0, 2, "R11 unknown instruction left array unchanged", 8'h00);

    csl(); sbyte(8'h03); sbyte(8'h00);
    csh();
    chk("R12 SO off after aborted READ", 16'(miso_en), 16'd0);
    rd_burst(16'h00F8, 2, "R1 new instruction after abort", 8'h00);
    chk("R12 SO off after read ends", 16'(miso_en), 16'd0);

    chk("R3 all expected read bytes seen", 16'(exp_q.size()), 16'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule